// File: doc/BRIEF.md
# Four-Level Preemptive Interrupt Arbiter

This block sits beside a small CPU core. It decides which of six peripheral interrupt sources the core should service next. The six sources are two external pins, three timers and a serial port. Each is conditioned by its own enable bit and by a global enable bit. Each source also has a two-bit priority built from one bit in a low priority register and one bit in a high priority register, so four preemption levels exist. Within a level, a fixed polling order breaks ties. The serial source is the OR of its receive and transmit flags. The third timer source is the OR of its overflow and external flags.

The arbiter presents a request together with a vector index and the winning level. When the core accepts the interrupt it pulses `irq_ack`, and the arbiter marks that level as in service. A later return pulse on `irq_ret` retires the most recent, highest in-service level. A request is raised only when the winner's level is strictly above every level now in service. Configuration is written through a small address/data/write-enable port, and a write takes effect from the following clock cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all enables and priorities are zero, no level is in service (`svc_busy`=0, `svc_lvl`=0), and no request is raised whatever the flags are.
- R2: Vector indices follow the polling order: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial (`ser_rx_flag` OR `ser_tx_flag`), 5 timer 2 (`tmr2_ovf_flag` OR `tmr2_ext_flag`).
- R3: A source can request only when its enable bit is set and the global enable is set. Enable bit n (n = vector index) is bit n of the enable register, and the global enable is bit 7.
- R4: The level of source n is 2·H[n] + L[n], where H is the high priority register and L the low one. When sources at different levels are pending, the highest level wins and `irq_lvl` shows it.
- R5: Among pending sources at the winning level, the lowest vector index wins.
- R6: While some level is in service, a request is raised only if the winner's level is strictly greater than the current in-service level. An equal or lower level waits.
- R7: While level 3 is in service, no request is raised.
- R8: `irq_ack` while a request is raised marks `irq_lvl` in service. `svc_lvl` is the highest in-service level and `svc_busy` is set while any level is in service.
- R9: `irq_ret` clears the highest in-service level. With nothing in service it has no effect.
- R10: Configuration writes select by `cfg_addr`: 0 enable register, 1 low priority register, 2 high priority register, 3 no effect. A write is visible from the next cycle.
- R11: `irq_ack` while no request is raised leaves the in-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_flag | input | 1 | External interrupt 0 flag |
| tmr0_flag | input | 1 | Timer 0 flag |
| ext1_flag | input | 1 | External interrupt 1 flag |
| tmr1_flag | input | 1 | Timer 1 flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag |
| tmr2_ext_flag | input | 1 | Timer 2 external event flag |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | DW (8) | Configuration write data |
| irq_ack | input | 1 | Core accepts the presented interrupt |
| irq_ret | input | 1 | Return from interrupt pulse |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Vector index of the winner |
| irq_lvl | output | 2 | Level of the winner |
| svc_busy | output | 1 | Some level is in service |
| svc_lvl | output | 2 | Highest in-service level |

## Verification
On every cycle, the assertions check the following. A request implies the global enable and a pending winner. Preemption is strictly upward, and level 3 blocks everything. An accepted request sets its level's in-service bit, a return removes exactly one bit, and a stray acknowledge or an empty return changes nothing. Which source wins among many pending sources at mixed levels cannot be expressed without restating the arbiter. That part, together with the flag merging and the register address decode, is shown only by the bench's sweeps over enables, priority patterns and all flag combinations, and by its nesting sequences.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC = 6;
  localparam int LVLW = 2;
  localparam int NLVL = 1 << LVLW;
  localparam int VECW = 3;

  typedef logic [LVLW-1:0] lvl_t;
  typedef logic [VECW-1:0] vec_t;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_PRIO_L = 2'd1,
    SEL_PRIO_H = 2'd2,
    SEL_UNUSED = 2'd3
  } cfg_sel_e;

  // Level of one source from its two priority bits
  function automatic lvl_t src_level(input logic hi_bit, input logic lo_bit);
    return {hi_bit, lo_bit};
  endfunction

  // Index of the most significant set bit of a level mask (0 when empty)
  function automatic lvl_t msb_index(input logic [NLVL-1:0] m);
    lvl_t r;
    r = '0;
    for (int k = 0; k < NLVL; k++) begin
      if (m[k]) r = lvl_t'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic            glb_en,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] prio_lo,
  output logic [NSRC-1:0] prio_hi
);
  localparam int GBIT = DW - 1;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      src_en  <= '0;
      prio_lo <= '0;
      prio_hi <= '0;
    end else if (we) begin
      case (sel)
        SEL_ENABLE: begin
          glb_en <= wdata[GBIT];
          src_en <= wdata[NSRC-1:0];
        end
        SEL_PRIO_L: prio_lo <= wdata[NSRC-1:0];
        SEL_PRIO_H: prio_hi <= wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
  import prio_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] prio_lo,
  input  logic [NSRC-1:0] prio_hi,
  output logic            any,
  output lvl_t            best_lvl,
  output vec_t            best_vec
);
  logic [NSRC-1:0] at_lvl [NLVL];
  logic [NLVL-1:0] lvl_hit;
  logic [NSRC-1:0] winners;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign at_lvl[g][s] = pend[s] && (src_level(prio_hi[s], prio_lo[s]) == lvl_t'(g));
    end
    assign lvl_hit[g] = |at_lvl[g];
  end

  assign any      = |lvl_hit;
  assign best_lvl = msb_index(lvl_hit);
  assign winners  = at_lvl[best_lvl];

  always_comb begin
    best_vec = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (winners[s]) best_vec = vec_t'(s);
    end
  end
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  lvl_t            push_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] isr,
  output logic            busy,
  output lvl_t            cur_lvl
);
  logic [NLVL-1:0] isr_nxt;

  assign busy    = |isr;
  assign cur_lvl = msb_index(isr);

  always_comb begin
    isr_nxt = isr;
    if (pop)  isr_nxt[cur_lvl]  = 1'b0;
    if (push) isr_nxt[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_nxt;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext0_flag,
  input  logic          tmr0_flag,
  input  logic          ext1_flag,
  input  logic          tmr1_flag,
  input  logic          ser_rx_flag,
  input  logic          ser_tx_flag,
  input  logic          tmr2_ovf_flag,
  input  logic          tmr2_ext_flag,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          irq_ack,
  input  logic          irq_ret,
  output logic          irq_req,
  output logic [2:0]    irq_vec,
  output logic [1:0]    irq_lvl,
  output logic          svc_busy,
  output logic [1:0]    svc_lvl
);
  logic            glb_en_w;
  logic [NSRC-1:0] src_en_w, prio_lo_w, prio_hi_w;
  logic [NSRC-1:0] src_flags_w, pend_w;
  logic            any_w, preempt_ok_w, push_w;
  lvl_t            best_lvl_w, cur_lvl_w;
  vec_t            best_vec_w;
  logic [NLVL-1:0] isr_w;
  logic            busy_w;

  assign src_flags_w = {tmr2_ovf_flag | tmr2_ext_flag, ser_rx_flag | ser_tx_flag,
                        tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};
  assign pend_w      = src_flags_w & src_en_w & {NSRC{glb_en_w}};

  prio_irq_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .glb_en(glb_en_w), .src_en(src_en_w), .prio_lo(prio_lo_w), .prio_hi(prio_hi_w)
  );

  prio_irq_pick u_pick (
    .pend(pend_w), .prio_lo(prio_lo_w), .prio_hi(prio_hi_w),
    .any(any_w), .best_lvl(best_lvl_w), .best_vec(best_vec_w)
  );

  assign preempt_ok_w = !busy_w || (best_lvl_w > cur_lvl_w);
  assign push_w       = irq_ack && irq_req;

  prio_irq_stack u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_w), .push_lvl(best_lvl_w), .pop(irq_ret),
    .isr(isr_w), .busy(busy_w), .cur_lvl(cur_lvl_w)
  );

  assign irq_req  = any_w && preempt_ok_w;
  assign irq_vec  = best_vec_w;
  assign irq_lvl  = best_lvl_w;
  assign svc_busy = busy_w;
  assign svc_lvl  = cur_lvl_w;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic [2:0] irq_vec,
  input logic [1:0] irq_lvl,
  input logic       svc_busy,
  input logic [1:0] svc_lvl,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       glb,
  input logic [5:0] pend,
  input logic [3:0] isr
);
  assert_req_needs_global_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glb);

  assert_vec_is_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec < 3'd6) && pend[irq_vec]);

  assert_preempt_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && svc_busy) |-> (irq_lvl > svc_lvl));

  assert_top_level_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    isr[3] |-> !irq_req);

  assert_ack_marks_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !irq_ret) |=> (isr[$past(irq_lvl)] && svc_busy));

  assert_ret_removes_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && (isr != 4'd0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  assert_ret_empty_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && (isr == 4'd0)) |=> (isr == 4'd0));

  assert_stray_ack_noop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !irq_ret) |=> $stable(isr));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
  .svc_busy(svc_busy), .svc_lvl(svc_lvl), .irq_ack(irq_ack), .irq_ret(irq_ret),
  .glb(glb_en_w), .pend(pend_w), .isr(isr_w)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/100ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] flags = 8'h00;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic [1:0] irq_lvl;
  logic       svc_busy;
  logic [1:0] svc_lvl;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side mirror of configuration and in-service levels
  logic [7:0] ie_m = 8'h00;
  logic [5:0] lo_m = 6'h00;
  logic [5:0] hi_m = 6'h00;
  logic [3:0] isr_m = 4'h0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ext0_flag(flags[0]), .tmr0_flag(flags[1]), .ext1_flag(flags[2]), .tmr1_flag(flags[3]),
    .ser_rx_flag(flags[4]), .ser_tx_flag(flags[5]), .tmr2_ovf_flag(flags[6]), .tmr2_ext_flag(flags[7]),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .svc_busy(svc_busy), .svc_lvl(svc_lvl)
  );

  function automatic int cur_level();
    int c;
    c = -1;
    for (int k = 0; k < 4; k++) if (isr_m[k]) c = k;
    return c;
  endfunction

  function automatic void model(input logic [7:0] raw, output logic r, output int v, output int l);
    logic [5:0] src;
    int best;
    src = {raw[6] | raw[7], raw[4] | raw[5], raw[3:0]};
    best = -1;
    v = 0;
    for (int lv = 3; lv >= 0; lv--) begin
      for (int k = 0; k < 6; k++) begin
        if (best < 0 && src[k] && ie_m[k] && ie_m[7] && (2 * int'(hi_m[k]) + int'(lo_m[k]) == lv)) begin
          best = lv;
          v = k;
        end
      end
    end
    l = (best < 0) ? 0 : best;
    r = (best >= 0) && (best > cur_level());
  endfunction

  task automatic check_val(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive flags at a falling edge, compare combinational outputs with the model
  task automatic probe(input string tag, input logic [7:0] raw);
    logic r;
    int v, l;
    @(negedge clk);
    flags = raw;
    #1;
    model(raw, r, v, l);
    check_val({tag, " req"}, int'(irq_req), int'(r));
    if (r) begin
      check_val({tag, " vec"}, int'(irq_vec), v);
      check_val({tag, " lvl"}, int'(irq_lvl), l);
    end
  endtask

  task automatic check_state(input string tag);
    int c;
    c = cur_level();
    #1;
    check_val({tag, " busy"}, int'(svc_busy), int'(c >= 0));
    check_val({tag, " svc_lvl"}, int'(svc_lvl), (c < 0) ? 0 : c);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: ie_m = d;
      2'd1: lo_m = d[5:0];
      2'd2: hi_m = d[5:0];
      default: ;
    endcase
  endtask

  task automatic set_levels(input int lv [6]);
    logic [7:0] lo, hi;
    lo = 8'h00; hi = 8'h00;
    for (int k = 0; k < 6; k++) begin
      lo[k] = lv[k][0];
      hi[k] = lv[k][1];
    end
    cfg_write(2'd1, lo);
    cfg_write(2'd2, hi);
  endtask

  task automatic do_ack(input logic [7:0] raw);
    logic r;
    int v, l;
    @(negedge clk);
    flags = raw;
    #1;
    model(raw, r, v, l);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    if (r) isr_m[l] = 1'b1;
  endtask

  task automatic do_ret();
    int c;
    @(negedge clk);
    irq_ret = 1'b1;
    @(negedge clk);
    irq_ret = 1'b0;
    c = cur_level();
    if (c >= 0) isr_m[c] = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lv [6];
    flags = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    #1;
    check_val("R1 req after reset", int'(irq_req), 0);
    check_val("R1 busy after reset", int'(svc_busy), 0);
    check_val("R1 svc_lvl after reset", int'(svc_lvl), 0);
    probe("R1 flags all set", 8'hFF);

    // R10: unused address has no effect; enable without global bit
    cfg_write(2'd3, 8'hFF);
    probe("R10 unused addr", 8'hFF);
    cfg_write(2'd0, 8'h3F);
    probe("R3 no global enable", 8'hFF);
    cfg_write(2'd0, 8'hBF);
    probe("R10 enable write visible", 8'hFF);
    check_val("R10 enable gives vec 0", int'(irq_vec), 0);

    // R3: sweep enable register
    for (int e = 0; e < 256; e++) begin
      cfg_write(2'd0, 8'(e));
      probe("R3 all flags", 8'hFF);
      probe("R3 even flags", 8'h55);
      probe("R3 odd flags", 8'hAA);
      for (int b = 0; b < 8; b++) probe("R3 single flag", 8'(1 << b));
    end

    // R2 and R5: flat priority, every flag pattern
    cfg_write(2'd0, 8'hBF);
    cfg_write(2'd1, 8'h00);
    cfg_write(2'd2, 8'h00);
    for (int f = 0; f < 256; f++) probe("R2 R5 flat order", 8'(f));

    // R4: mixed priority patterns, every flag pattern
    for (int a = 0; a < 64; a++) begin
      cfg_write(2'd1, 8'(a));
      cfg_write(2'd2, 8'((a * 37) & 63));
      for (int f = 0; f < 256; f++) probe("R4 mixed levels", 8'(f));
    end

    // R6 and R7: preemption against each in-service level
    for (int L = 0; L < 4; L++) begin
      for (int M = 0; M < 4; M++) begin
        lv = '{L, 0, 0, 0, 0, M};
        set_levels(lv);
        do_ack(8'h01);
        check_state("R8 ack pushes level");
        probe((L == 3) ? "R7 level3 blocks timer2" : "R6 preempt by timer2", 8'h40);
        probe((L == 3) ? "R7 level3 blocks same" : "R6 same level waits", 8'h01);
        probe("R6 both pending", 8'h41);
        do_ack(8'h00);
        check_state("R11 stray ack ignored");
        do_ret();
        check_state("R9 ret pops");
      end
    end

    // R8 and R9: full nesting through all four levels
    lv = '{0, 1, 2, 3, 0, 0};
    set_levels(lv);
    do_ack(8'h01);
    check_state("R8 nest level0");
    do_ack(8'h03);
    check_state("R8 nest level1");
    do_ack(8'h07);
    check_state("R8 nest level2");
    probe("R6 lower waits in nest", 8'h03);
    do_ack(8'h03);
    check_state("R11 ack on blocked request ignored");
    do_ack(8'h0F);
    check_state("R8 nest level3");
    probe("R7 all blocked", 8'hFF);
    do_ret();
    check_state("R9 pop to level2");
    probe("R6 level3 preempts level2", 8'h0F);
    do_ret();
    check_state("R9 pop to level1");
    do_ret();
    check_state("R9 pop to level0");
    do_ret();
    check_state("R9 pop to idle");
    do_ret();
    check_state("R9 ret when idle ignored");
    probe("R9 request after empty ret", 8'h01);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule